// File: doc/BRIEF.md
# JTAG Debug Port Access Engine

This block sits behind a JTAG TAP controller on the target side. It turns scans of a 35-bit access data register into reads and writes of debug-port registers and of one internal access port. The TAP controller is outside the block. It supplies the current instruction, one-cycle capture, shift and update strobes, and a tick for every TCK cycle spent in Run-Test/Idle. Serial data goes in on `tdi` and comes out on `tdo`, least significant bit first. The block has no valid/ready stream interface: every pin is a plain TAP strobe or a serial bit, and the TAP timing sets the pace. Back-pressure reaches the host only as the WAIT acknowledge.

Every access scan returns two things: a 3-bit acknowledge, and the read result that the previous read left behind. Reads are posted, so the host collects a result on the following scan, or by reading the read buffer. An access-port transaction stays busy for a programmable number of idle ticks. An access that arrives while it is busy is answered WAIT and has no effect. If overrun detection is enabled, that WAIT also sets a sticky overrun flag. An access-port transaction that targets an absent port or bank sets a sticky error flag. While that flag is set, further access-port transactions are dropped without any response. The ABORT instruction cancels a busy transaction.

Top module: `dpa_engine`

## Requirements
- R1: A capture under instruction 4'hA (debug-port access) or 4'hB (access-port access) loads the acknowledge into DR bits 2:0, which are shifted out first. The acknowledge is 3'b010 (OK) when no access-port transaction is busy.
- R2: Under instruction 4'hE, a capture loads the 32-bit IDCODE parameter, and it is shifted out LSB first.
- R3: The DR takes bit 0 = read-not-write, bits 2:1 = address word A[3:2] and bits 34:3 = data. A read stores its result in the read buffer, and the next access scan returns that buffer in bits 34:3. Debug-port words are 1 = control/status, 2 = select and 3 = read buffer. All of them read 0 after reset.
- R4: A debug-port read of word 3 returns the read buffer and leaves it unchanged.
- R5: An access-port transaction stays busy for AP_LATENCY Run-Test/Idle ticks. Any access captured while it is busy gets 3'b001 (WAIT), and its write or read is discarded.
- R6: Control/status bit 0 enables overrun detection. While it is set, a WAIT sets the sticky overrun flag in bit 1. While it is clear, a WAIT leaves bit 1 alone.
- R7: Writing 1 to control/status bit 1 or bit 5 clears that sticky flag. Writing 0 leaves it unchanged.
- R8: An access-port transaction to a port number other than 0, or to a bank at or above AP_BANKS, completes at once and sets sticky error bit 5. While bit 5 is set, access-port transactions are discarded and do not become busy.
- R9: Select bits 31:24 choose the port and select bits 7:4 choose the bank. The access-port word is bank*4 + A.
- R10: Control/status bits 28 and 30 are stored requests. They read back in bits 29 and 31 as acknowledges.
- R11: A DR update under instruction 4'h8 with data 1 cancels the busy transaction and drops its pending write or read. Any other data value does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Active-low reset |
| ir | input | 4 | Current instruction from the TAP |
| capture_dr | input | 1 | Capture-DR strobe |
| shift_dr | input | 1 | Shift-DR strobe |
| update_dr | input | 1 | Update-DR strobe |
| rti_tick | input | 1 | One cycle spent in Run-Test/Idle |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |

## Verification
The bench builds the block with AP_LATENCY = 3 and AP_BANKS = 2. With a latency of 3, a scan issued straight after an access-port transaction always lands in the busy window, which makes WAIT, discarded writes, overrun and ABORT reachable. Three idle ticks then close the window. With two banks, bank 1 holds data that differs from bank 0, and bank 2 is the first out-of-range bank, so the sticky error path is reachable.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  localparam logic [3:0] IR_ABORT  = 4'h8;
  localparam logic [3:0] IR_DPACC  = 4'hA;
  localparam logic [3:0] IR_APACC  = 4'hB;
  localparam logic [3:0] IR_IDCODE = 4'hE;

  localparam logic [2:0] ACK_OK   = 3'b010;
  localparam logic [2:0] ACK_WAIT = 3'b001;

  localparam int DATA_W = 32;
  localparam int DR_W   = DATA_W + 3;

  typedef enum logic [1:0] {
    DPW_NONE = 2'd0,
    DPW_CTRL = 2'd1,
    DPW_SEL  = 2'd2,
    DPW_RBUF = 2'd3
  } dp_word_e;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic [1:0]        word;
    logic              rnw;
  } acc_req_t;
endpackage

// File: rtl/dpa_shift_chain.sv
module dpa_shift_chain #(
  parameter int W = 35
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic         capture,
  input  logic         shift,
  input  logic [W-1:0] load_val,
  input  logic         tdi,
  output logic         tdo,
  output logic [W-1:0] sr
);
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)      sr <= '0;
    else if (capture) sr <= load_val;
    else if (shift)   sr <= {tdi, sr[W-1:1]};
  end

  assign tdo = sr[0];
endmodule

// File: rtl/dpa_ap_bank.sv
module dpa_ap_bank #(
  parameter int LATENCY = 3,
  parameter int BANKS   = 2,
  parameter int DW      = 32
) (
  input  logic          tck,
  input  logic          trst_n,
  input  logic          start,
  input  logic          rnw,
  input  logic [1:0]    word,
  input  logic [3:0]    bank,
  input  logic [7:0]    port,
  input  logic [DW-1:0] wdata,
  input  logic          tick,
  input  logic          abort,
  output logic          busy,
  output logic          fault,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  localparam int WORDS = BANKS * 4;
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic              hit;
  logic [IDX_W-1:0]  req_idx;
  logic              cmp;
  logic              cmp_wr;
  logic [IDX_W-1:0]  cmp_idx;
  logic [DW-1:0]     cmp_data;
  logic [DW-1:0]     mem [WORDS];

  assign hit     = (port == 8'd0) && (int'(bank) < BANKS);
  assign req_idx = IDX_W'({bank, word});
  assign fault   = start && !hit;

  generate
    if (LATENCY == 0) begin : g_instant
      logic unused_lat0;
      assign unused_lat0 = tick ^ abort;
      assign busy     = 1'b0;
      assign cmp      = start && hit;
      assign cmp_wr   = !rnw;
      assign cmp_idx  = req_idx;
      assign cmp_data = wdata;
    end else begin : g_timed
      localparam int CNT_W = $clog2(LATENCY + 1);
      logic [CNT_W-1:0] cnt;
      logic             p_wr;
      logic [IDX_W-1:0] p_idx;
      logic [DW-1:0]    p_data;

      always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
          cnt    <= '0;
          p_wr   <= 1'b0;
          p_idx  <= '0;
          p_data <= '0;
        end else if (abort) begin
          cnt <= '0;
        end else if (start && hit) begin
          cnt    <= CNT_W'(LATENCY);
          p_wr   <= !rnw;
          p_idx  <= req_idx;
          p_data <= wdata;
        end else if (tick && cnt != '0) begin
          cnt <= cnt - 1'b1;
        end
      end

      assign busy     = (cnt != '0);
      assign cmp      = tick && (cnt == CNT_W'(1)) && !abort;
      assign cmp_wr   = p_wr;
      assign cmp_idx  = p_idx;
      assign cmp_data = p_data;
    end
  endgenerate

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (cmp && cmp_wr) begin
      mem[cmp_idx] <= cmp_data;
    end
  end

  assign rd_valid = cmp && !cmp_wr;
  assign rd_data  = mem[cmp_idx];
endmodule

// File: rtl/dpa_dp_regs.sv
module dpa_dp_regs
  import dpa_pkg::*;
(
  input  logic              tck,
  input  logic              trst_n,
  input  logic              wait_seen,
  input  logic              dp_wr,
  input  logic              dp_rd,
  input  logic [1:0]        dp_word,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ap_fault,
  input  logic              ap_rd_valid,
  input  logic [DATA_W-1:0] ap_rd_data,
  output logic [DATA_W-1:0] rdbuff,
  output logic [7:0]        ap_sel,
  output logic [3:0]        bank_sel,
  output logic              orun_det,
  output logic              sticky_orun,
  output logic              sticky_err
);
  logic              pwr_dbg, pwr_sys;
  logic [DATA_W-1:0] sel_q;
  logic [DATA_W-1:0] ctrl_word;

  assign ctrl_word = {pwr_sys, pwr_sys, pwr_dbg, pwr_dbg, 22'd0,
                      sticky_err, 3'd0, sticky_orun, orun_det};
  assign ap_sel    = sel_q[31:24];
  assign bank_sel  = sel_q[7:4];

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      pwr_dbg     <= 1'b0;
      pwr_sys     <= 1'b0;
      orun_det    <= 1'b0;
      sticky_orun <= 1'b0;
      sticky_err  <= 1'b0;
      sel_q       <= '0;
      rdbuff      <= '0;
    end else begin
      if (wait_seen && orun_det) sticky_orun <= 1'b1;
      if (ap_fault) sticky_err <= 1'b1;
      if (dp_wr) begin
        case (dp_word_e'(dp_word))
          DPW_CTRL: begin
            orun_det <= wdata[0];
            pwr_dbg  <= wdata[28];
            pwr_sys  <= wdata[30];
            if (wdata[1]) sticky_orun <= 1'b0;
            if (wdata[5]) sticky_err  <= 1'b0;
          end
          DPW_SEL: sel_q <= wdata;
          default: ;
        endcase
      end
      if (ap_rd_valid) begin
        rdbuff <= ap_rd_data;
      end else if (dp_rd) begin
        case (dp_word_e'(dp_word))
          DPW_CTRL: rdbuff <= ctrl_word;
          DPW_SEL:  rdbuff <= sel_q;
          DPW_RBUF: rdbuff <= rdbuff;
          default:  rdbuff <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/dpa_engine.sv
module dpa_engine
  import dpa_pkg::*;
#(
  parameter int          AP_LATENCY = 3,
  parameter int          AP_BANKS   = 2,
  parameter logic [31:0] IDCODE_VAL = 32'h4D5A_1001
) (
  input  logic       tck,
  input  logic       trst_n,
  input  logic [3:0] ir,
  input  logic       capture_dr,
  input  logic       shift_dr,
  input  logic       update_dr,
  input  logic       rti_tick,
  input  logic       tdi,
  output logic       tdo
);
  logic              is_acc;
  logic              wait_q;
  logic [DR_W-1:0]   load_val;
  logic [DR_W-1:0]   sr;
  acc_req_t          req;
  logic              ap_busy, ap_fault, ap_rd_valid;
  logic [DATA_W-1:0] ap_rd_data;
  logic [DATA_W-1:0] rdbuff;
  logic [7:0]        ap_sel;
  logic [3:0]        bank_sel;
  logic              orun_det, sticky_orun, sticky_err;
  logic              dp_wr, dp_rd, ap_start, abort_req, wait_seen;

  assign is_acc = (ir == IR_DPACC) || (ir == IR_APACC);
  assign req    = sr;

  always_comb begin
    case (ir)
      IR_DPACC, IR_APACC: load_val = {rdbuff, ap_busy ? ACK_WAIT : ACK_OK};
      IR_IDCODE:          load_val = {3'b000, IDCODE_VAL};
      IR_ABORT:           load_val = {{DATA_W{1'b0}}, ACK_OK};
      default:            load_val = '0;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)         wait_q <= 1'b0;
    else if (capture_dr) wait_q <= is_acc && ap_busy;
  end

  assign wait_seen = capture_dr && is_acc && ap_busy;
  assign dp_wr     = update_dr && (ir == IR_DPACC) && !wait_q && !req.rnw;
  assign dp_rd     = update_dr && (ir == IR_DPACC) && !wait_q &&  req.rnw;
  assign ap_start  = update_dr && (ir == IR_APACC) && !wait_q && !sticky_err;
  assign abort_req = update_dr && (ir == IR_ABORT) && (req.data == 32'd1);

  dpa_shift_chain #(.W(DR_W)) u_chain (
    .tck(tck), .trst_n(trst_n), .capture(capture_dr), .shift(shift_dr),
    .load_val(load_val), .tdi(tdi), .tdo(tdo), .sr(sr)
  );

  dpa_dp_regs u_dp (
    .tck(tck), .trst_n(trst_n), .wait_seen(wait_seen),
    .dp_wr(dp_wr), .dp_rd(dp_rd), .dp_word(req.word), .wdata(req.data),
    .ap_fault(ap_fault), .ap_rd_valid(ap_rd_valid), .ap_rd_data(ap_rd_data),
    .rdbuff(rdbuff), .ap_sel(ap_sel), .bank_sel(bank_sel),
    .orun_det(orun_det), .sticky_orun(sticky_orun), .sticky_err(sticky_err)
  );

  dpa_ap_bank #(.LATENCY(AP_LATENCY), .BANKS(AP_BANKS), .DW(DATA_W)) u_ap (
    .tck(tck), .trst_n(trst_n), .start(ap_start), .rnw(req.rnw),
    .word(req.word), .bank(bank_sel), .port(ap_sel), .wdata(req.data),
    .tick(rti_tick), .abort(abort_req), .busy(ap_busy), .fault(ap_fault),
    .rd_valid(ap_rd_valid), .rd_data(ap_rd_data)
  );
endmodule

// File: rtl/dpa_engine_chk.sv
module dpa_engine_chk
  import dpa_pkg::*;
(
  input logic            tck,
  input logic            trst_n,
  input logic [3:0]      ir,
  input logic            capture_dr,
  input logic            update_dr,
  input logic            ap_busy,
  input logic            orun_det,
  input logic            sticky_orun,
  input logic            sticky_err,
  input logic [DR_W-1:0] sr
);
  logic acc_ir;
  assign acc_ir = (ir == IR_DPACC) || (ir == IR_APACC);

  AST_ACK_LEGAL: assert property (@(posedge tck) disable iff (!trst_n)
    capture_dr && acc_ir |=> (sr[2:0] == ACK_OK) || (sr[2:0] == ACK_WAIT)); // R1

  AST_WAIT_WHEN_BUSY: assert property (@(posedge tck) disable iff (!trst_n)
    capture_dr && acc_ir && ap_busy |=> sr[2:0] == ACK_WAIT); // R5

  AST_ORUN_ON_WAIT: assert property (@(posedge tck) disable iff (!trst_n)
    capture_dr && acc_ir && ap_busy && orun_det |=> sticky_orun); // R6

  AST_ERR_BLOCKS_AP: assert property (@(posedge tck) disable iff (!trst_n)
    update_dr && (ir == IR_APACC) && sticky_err && !ap_busy |=> !ap_busy); // R8

  AST_ABORT_FREES: assert property (@(posedge tck) disable iff (!trst_n)
    update_dr && (ir == IR_ABORT) && (sr[DR_W-1:3] == 32'd1) |=> !ap_busy); // R11
endmodule

bind dpa_engine dpa_engine_chk u_chk (
  .tck(tck), .trst_n(trst_n), .ir(ir), .capture_dr(capture_dr),
  .update_dr(update_dr), .ap_busy(ap_busy), .orun_det(orun_det),
  .sticky_orun(sticky_orun), .sticky_err(sticky_err), .sr(sr)
);

// File: tb/tb_dpa_engine.sv
`timescale 1ns/1ps
module tb_dpa_engine;
  localparam logic [31:0] IDC = 32'h4D5A_1001;
  localparam logic [3:0] I_AB = 4'h8, I_DP = 4'hA, I_AP = 4'hB, I_ID = 4'hE;
  localparam logic [2:0] OK = 3'b010, WT = 3'b001;

  logic tck = 1'b0, trst_n = 1'b0;
  logic [3:0] ir = 4'h0;
  logic capture_dr = 0, shift_dr = 0, update_dr = 0, rti_tick = 0, tdi = 0;
  logic tdo;
  int checks = 0, failures = 0;

  always #10 tck = ~tck;

  dpa_engine #(.AP_LATENCY(3), .AP_BANKS(2), .IDCODE_VAL(IDC)) dut (
    .tck(tck), .trst_n(trst_n), .ir(ir), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .rti_tick(rti_tick),
    .tdi(tdi), .tdo(tdo)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic scan(input logic [3:0] ins, input logic [34:0] din, input int nb,
                      output logic [34:0] dout);
    dout = '0;
    @(negedge tck); ir = ins; capture_dr = 1;
    @(negedge tck); capture_dr = 0; shift_dr = 1;
    for (int i = 0; i < nb; i++) begin
      tdi = din[i]; #1; dout[i] = tdo; @(negedge tck);
    end
    shift_dr = 0; update_dr = 1;
    @(negedge tck); update_dr = 0;
  endtask

  task automatic acc(input logic [3:0] ins, input logic [1:0] a, input logic rnw,
                     input logic [31:0] d, output logic [2:0] ack, output logic [31:0] rd);
    logic [34:0] o;
    scan(ins, {d, a, rnw}, 35, o);
    ack = o[2:0]; rd = o[34:3];
  endtask

  task automatic idle(input int n);
    @(negedge tck); rti_tick = 1;
    repeat (n) @(negedge tck);
    rti_tick = 0;
  endtask

  logic [2:0] k;
  logic [31:0] r;
  logic [34:0] o;

  task automatic t_reset();
    acc(I_DP, 2'd1, 1, 0, k, r);
    check("R1 ack ok", {29'd0, k}, {29'd0, OK});
    check("R3 reset rdbuff", r, 0);
    acc(I_DP, 2'd3, 1, 0, k, r);
    check("R3 reset ctrl", r, 0);
  endtask

  task automatic t_idcode();
    scan(I_ID, '0, 32, o);
    check("R2 idcode", o[31:0], IDC);
  endtask

  task automatic t_power();
    acc(I_DP, 2'd2, 0, 32'h0000_0010, k, r);
    acc(I_DP, 2'd1, 0, 32'h5000_0001, k, r);
    acc(I_DP, 2'd1, 1, 0, k, r);
    acc(I_DP, 2'd3, 1, 0, k, r);
    check("R10 power ack", r, 32'hF000_0001);
    acc(I_DP, 2'd3, 1, 0, k, r);
    check("R4 rdbuff repeat", r, 32'hF000_0001);
    check("R4 rdbuff ack", {29'd0, k}, {29'd0, OK});
  endtask

  task automatic t_wait_orun();
    acc(I_AP, 2'd2, 0, 32'hCAFE_0012, k, r);
    acc(I_AP, 2'd2, 1, 0, k, r);
    check("R5 wait ack", {29'd0, k}, {29'd0, WT});
    idle(3);
    acc(I_DP, 2'd1, 1, 0, k, r);
    acc(I_DP, 2'd3, 1, 0, k, r);
    check("R6 overrun set", r, 32'hF000_0003);
    acc(I_DP, 2'd1, 0, 32'h5000_0003, k, r);
    acc(I_DP, 2'd1, 1, 0, k, r);
    acc(I_DP, 2'd3, 1, 0, k, r);
    check("R7 overrun cleared", r, 32'hF000_0001);
  endtask

  task automatic t_posted();
    acc(I_AP, 2'd2, 1, 0, k, r);
    check("R3 ap read ack", {29'd0, k}, {29'd0, OK});
    idle(3);
    acc(I_DP, 2'd3, 1, 0, k, r);
    check("R3 R9 posted bank1", r, 32'hCAFE_0012);
    acc(I_DP, 2'd2, 0, 32'h0000_0000, k, r);
    acc(I_AP, 2'd2, 1, 0, k, r);
    idle(3);
    acc(I_DP, 2'd3, 1, 0, k, r);
    check("R9 bank0 word2", r, 0);
  endtask

  task automatic t_discard();
    acc(I_DP, 2'd1, 0, 32'h5000_0000, k, r);
    acc(I_AP, 2'd0, 0, 32'h0000_1111, k, r);
    acc(I_AP, 2'd0, 0, 32'h0000_2222, k, r);
    check("R5 second write wait", {29'd0, k}, {29'd0, WT});
    idle(3);
    acc(I_AP, 2'd0, 1, 0, k, r);
    idle(3);
    acc(I_DP, 2'd3, 1, 0, k, r);
    check("R5 write discarded", r, 32'h0000_1111);
    acc(I_DP, 2'd1, 1, 0, k, r);
    acc(I_DP, 2'd3, 1, 0, k, r);
    check("R6 no overrun when disabled", r, 32'hF000_0000);
  endtask

  task automatic t_abort();
    acc(I_DP, 2'd1, 1, 0, k, r);
    acc(I_AP, 2'd0, 1, 0, k, r);
    scan(I_AB, {32'd1, 3'b000}, 35, o);
    acc(I_DP, 2'd3, 1, 0, k, r);
    check("R11 abort frees", {29'd0, k}, {29'd0, OK});
    check("R11 pending read dropped", r, 32'hF000_0000);
    acc(I_AP, 2'd0, 0, 32'h0000_3333, k, r);
    scan(I_AB, {32'd2, 3'b000}, 35, o);
    acc(I_DP, 2'd3, 1, 0, k, r);
    check("R11 abort other value ignored", {29'd0, k}, {29'd0, WT});
    idle(3);
  endtask

  task automatic t_sticky();
    acc(I_DP, 2'd2, 0, 32'h0100_0000, k, r);
    acc(I_AP, 2'd0, 0, 32'h0000_4444, k, r);
    acc(I_DP, 2'd1, 1, 0, k, r);
    check("R8 fault not busy", {29'd0, k}, {29'd0, OK});
    acc(I_DP, 2'd3, 1, 0, k, r);
    check("R8 sticky err set", r, 32'hF000_0020);
    acc(I_DP, 2'd2, 0, 32'h0000_0000, k, r);
    acc(I_AP, 2'd0, 0, 32'h0000_5555, k, r);
    acc(I_AP, 2'd0, 1, 0, k, r);
    check("R8 ap discarded no busy", {29'd0, k}, {29'd0, OK});
    acc(I_DP, 2'd1, 0, 32'h5000_0020, k, r);
    acc(I_AP, 2'd0, 1, 0, k, r);
    idle(3);
    acc(I_DP, 2'd3, 1, 0, k, r);
    check("R8 R7 write dropped then cleared", r, 32'h0000_3333);
    acc(I_DP, 2'd2, 0, 32'h0000_0020, k, r);
    acc(I_AP, 2'd0, 1, 0, k, r);
    acc(I_DP, 2'd1, 1, 0, k, r);
    acc(I_DP, 2'd3, 1, 0, k, r);
    check("R8 bank out of range", r, 32'hF000_0020);
  endtask

  initial begin
    repeat (3) @(negedge tck);
    trst_n = 1;
    fork
      begin
        t_reset(); t_idcode(); t_power(); t_wait_orun();
        t_posted(); t_discard(); t_abort(); t_sticky();
      end
      begin
        repeat (150000) @(posedge tck);
        checks++; failures++;
        $display("FAIL watchdog all R actual=timeout expected=finish");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule